// File: doc/BRIEF.md
# Strobe-Qualified Parallel Input Capture

This block takes a parallel data bus, a few side-band bits and a slow strobe from an outside source. None of these inputs is synchronous to the fast internal clock. The strobe is never used as a clock. It is treated as one more data bit, and every piece of logic in the block runs on the internal clock. Each input goes through two internal-clock registers. Only the second register feeds any logic. An edge detector on the resynchronised strobe picks out the one internal cycle in which the strobe has just reached its active level. In that cycle it latches the resynchronised data and side-band bits, which came through the same two stages.

The captured word leaves the block as a single-cycle valid flag with the data and side-band bits beside it, so it can feed a FIFO write port directly. A run-time setting holds the flag and its word back by 0 to 7 extra internal cycles, and the two stay aligned. The strobe edge that qualifies a word is chosen at compile time. A rising-edge build suits sources that change data on the falling edge, and a falling-edge build suits sources that change data on the rising edge. A wrapping count of emitted words lets a system check that exactly one word arrives per strobe period.

Top module: `strobe_capture`

## Requirements
- R1: Every input passes through two internal-clock registers. For the rising-edge build with a capture delay of 0, a strobe rise that is sampled at clock edge E0 drives `word_valid` high during the cycle that follows edge E2. It is low in the cycle before that.
- R2: In the rising-edge build (EDGE_SEL = EDGE_RISE), each low-to-high strobe transition gives exactly one `word_valid` cycle, however long the strobe then stays high. A high-to-low transition gives none.
- R3: In the falling-edge build (EDGE_SEL = EDGE_FALL), each high-to-low strobe transition gives one `word_valid` cycle with the same latency as in R1. A low-to-high transition gives none.
- R4: While `word_valid` is high, `word_data` and `word_side` hold the `ext_data` and `ext_side` values that were held stable around the qualifying strobe transition.
- R5: When `cap_dly` = d (0 to 7), `word_valid` and its word appear d cycles later than in R1, still for exactly one cycle and still aligned.
- R6: While the strobe does not toggle, no word is emitted. When the strobe toggles again, capture resumes without a reset.
- R7: A synchronous active-high `rst` clears `word_valid`, `word_data`, `word_side` and `word_count` to zero. A strobe held at its active level through reset and afterwards produces no word.
- R8: `word_count` rises by one in the cycle after each `word_valid` cycle and wraps to zero after 2^CNT_W words.
- R9: With a strobe period of four internal cycles (two high, two low), where data changes while the strobe is low, every word is captured in order with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_strobe | input | 1 | Outside strobe, asynchronous to clk |
| ext_data | input | DATA_W | Outside data bus, asynchronous to clk |
| ext_side | input | SIDE_W | Outside side-band bits (line/frame markers), asynchronous to clk |
| cap_dly | input | DLY_W | Extra cycles of delay for valid and word, 0 to 2^DLY_W-1 |
| word_valid | output | 1 | One-cycle flag for a captured word |
| word_data | output | DATA_W | Captured data word |
| word_side | output | SIDE_W | Captured side-band bits |
| word_count | output | CNT_W | Wrapping count of emitted words |

## Verification
The hardest case to reach is a strobe that already sits at its active level when reset is released. The detector's memory of the previous strobe value starts at zero, so without protection this would look like a fresh edge. The stimulus holds the strobe high across reset and for many cycles after it, and expects silence. A second subtle case is a delay change: stale words can linger in the deeper delay stages. The delay sweep therefore lets the line drain before each new setting, and then checks the exact arrival cycle for every value from 0 to 7.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // Which strobe transition qualifies a word.
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   // Upper limit on the delay-select width (2^3 = 8 taps).
   localparam int DLY_W_LIMIT = 3;
endpackage

// File: rtl/cap_sync2.sv
module cap_sync2 #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   // First stage only absorbs timing violations; logic reads q alone.
   logic [W-1:0] guard_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         guard_q <= '0;
         q       <= '0;
      end else begin
         guard_q <= d;
         q       <= guard_q;
      end
   end
endmodule

// File: rtl/cap_edge.sv
module cap_edge #(
   parameter cap_pkg::edge_sel_e SEL = cap_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   output logic pulse
);
   logic       prev_q;
   logic [1:0] warm_q;
   logic       armed;
   logic       hit;

   // Hold the detector off until the two sync stages and prev_q hold real samples.
   assign armed = (warm_q == 2'd3);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         warm_q <= 2'd0;
      end else begin
         prev_q <= sig;
         if (!armed) warm_q <= warm_q + 2'd1;
      end
   end

   generate
      if (SEL == cap_pkg::EDGE_FALL) begin : g_fall
         assign hit = prev_q & ~sig;
      end else begin : g_rise
         assign hit = sig & ~prev_q;
      end
   endgenerate

   assign pulse = hit & armed;

   // R2 / R3: a qualifying transition yields a single-cycle pulse
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);
endmodule

// File: rtl/cap_delay.sv
module cap_delay #(
   parameter int W     = 8,
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [W-1:0]     in_word,
   input  logic [DLY_W-1:0] dly,
   output logic             out_valid,
   output logic [W-1:0]     out_word
);
   localparam int DEPTH = 1 << DLY_W;

   logic [DEPTH-1:0] v_q;
   logic [W-1:0]     w_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
         for (int i = 0; i < DEPTH; i++) w_q[i] <= '0;
      end else begin
         v_q[0] <= in_valid;
         w_q[0] <= in_word;
         for (int i = 1; i < DEPTH; i++) begin
            v_q[i] <= v_q[i-1];
            w_q[i] <= w_q[i-1];
         end
      end
   end

   // Flag and word come from the same tap, so they stay aligned.
   assign out_valid = v_q[dly];
   assign out_word  = w_q[dly];

   // R5: with zero delay a pulse appears exactly one register later
   assert_zero_delay_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && (dly == '0)) |-> out_valid);
endmodule

// File: rtl/strobe_capture.sv
module strobe_capture #(
   parameter int                 DATA_W   = 8,
   parameter int                 SIDE_W   = 2,
   parameter int                 DLY_W    = 3,
   parameter int                 CNT_W    = 16,
   parameter cap_pkg::edge_sel_e EDGE_SEL = cap_pkg::EDGE_RISE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ext_strobe,
   input  logic [DATA_W-1:0] ext_data,
   input  logic [SIDE_W-1:0] ext_side,
   input  logic [DLY_W-1:0]  cap_dly,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data,
   output logic [SIDE_W-1:0] word_side,
   output logic [CNT_W-1:0]  word_count
);
   localparam int   WORD_W  = DATA_W + SIDE_W;
   localparam int   BUS_W   = 1 + WORD_W;
   localparam logic ACT_LVL = (EDGE_SEL == cap_pkg::EDGE_RISE);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (SIDE_W < 1) begin : g_bad_side
         $error("SIDE_W must be at least 1");
      end
      if (DLY_W < 1 || DLY_W > cap_pkg::DLY_W_LIMIT) begin : g_bad_dly
         $error("DLY_W must lie in 1..3");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0]  bus_s;
   logic              strobe_s;
   logic [WORD_W-1:0] word_s;
   logic              cap_pulse;
   logic [WORD_W-1:0] word_d;

   cap_sync2 #(.W(BUS_W)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   ({ext_side, ext_data, ext_strobe}),
      .q   (bus_s)
   );

   assign strobe_s = bus_s[0];
   assign word_s   = bus_s[BUS_W-1:1];

   cap_edge #(.SEL(EDGE_SEL)) edge_i (
      .clk   (clk),
      .rst   (rst),
      .sig   (strobe_s),
      .pulse (cap_pulse)
   );

   cap_delay #(.W(WORD_W), .DLY_W(DLY_W)) delay_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (cap_pulse),
      .in_word   (word_s),
      .dly       (cap_dly),
      .out_valid (word_valid),
      .out_word  (word_d)
   );

   assign word_data = word_d[DATA_W-1:0];
   assign word_side = word_d[WORD_W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (rst)             word_count <= '0;
      else if (word_valid) word_count <= word_count + CNT_W'(1);
   end

   // R1: a pulse means the pin showed the active level two samples ago
   assert_sync_path_R1: assert property (@(posedge clk) disable iff (rst)
      cap_pulse |-> ($past(ext_strobe, 2) == ACT_LVL));

   // R6: no pulse while the synchronised strobe holds still
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      cap_pulse |-> !$stable(strobe_s));

   // R8: count steps by exactly one after each emitted word
   assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> (word_count == $past(word_count) + CNT_W'(1)));
endmodule

// File: tb/strobe_capture_tb_top.sv
module strobe_capture_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       stb_r = 1'b0;
   logic       stb_f = 1'b0;
   logic [7:0] ext_data = '0;
   logic [1:0] ext_side = '0;
   logic [2:0] dly_r = '0;
   logic [2:0] dly_f = '0;

   logic       v_r, v_f;
   logic [7:0] d_r, d_f;
   logic [1:0] s_r, s_f;
   logic [3:0] c_r, c_f;

   int checks = 0;
   int fails  = 0;
   int rx_n   = 0;
   int fx_n   = 0;
   logic [7:0] rx_data [64];
   logic       done = 1'b0;

   always #10 clk = ~clk;

   strobe_capture #(.DATA_W(8), .SIDE_W(2), .DLY_W(3), .CNT_W(4),
                    .EDGE_SEL(cap_pkg::EDGE_RISE)) dut_i (
      .clk(clk), .rst(rst), .ext_strobe(stb_r), .ext_data(ext_data),
      .ext_side(ext_side), .cap_dly(dly_r), .word_valid(v_r),
      .word_data(d_r), .word_side(s_r), .word_count(c_r));

   strobe_capture #(.DATA_W(8), .SIDE_W(2), .DLY_W(3), .CNT_W(4),
                    .EDGE_SEL(cap_pkg::EDGE_FALL)) dut_fall_i (
      .clk(clk), .rst(rst), .ext_strobe(stb_f), .ext_data(ext_data),
      .ext_side(ext_side), .cap_dly(dly_f), .word_valid(v_f),
      .word_data(d_f), .word_side(s_f), .word_count(c_f));

   // Word monitor, sampled on the falling clock edge
   always @(negedge clk) begin
      if (!rst && v_r) begin
         if (rx_n < 64) rx_data[rx_n] = d_r;
         rx_n = rx_n + 1;
      end
      if (!rst && v_f) fx_n = fx_n + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // One word on the rising-edge instance with exact latency checks
   task automatic send_r(input logic [7:0] dat, input logic [1:0] sd, input int d);
      int start;
      int cbefore;
      stb_r = 1'b0;
      wait_cyc(10);
      dly_r    = 3'(d);
      ext_data = dat;
      ext_side = sd;
      wait_cyc(3);
      start   = rx_n;
      cbefore = int'(c_r);
      stb_r   = 1'b1;
      wait_cyc(2 + d);
      chk(rx_n == start && v_r == 1'b0, d == 0 ? "R1 early" : "R5 early", rx_n - start, 0);
      wait_cyc(1);
      chk(v_r == 1'b1, d == 0 ? "R1 latency" : "R5 latency", int'(v_r), 1);
      chk(d_r == dat && s_r == sd, "R4 word", int'({s_r, d_r}), int'({sd, dat}));
      wait_cyc(1);
      chk(v_r == 1'b0, "R2 one cycle", int'(v_r), 0);
      chk(int'(c_r) == ((cbefore + 1) % 16), "R8 step", int'(c_r), (cbefore + 1) % 16);
   endtask

   task automatic t_reset;
      stb_r = 1'b1;
      rst   = 1'b1;
      wait_cyc(4);
      chk(v_r == 0 && d_r == 0 && s_r == 0 && c_r == 0, "R7 reset values",
          int'({v_r, s_r, d_r, c_r}), 0);
      rst = 1'b0;
      wait_cyc(12);
      chk(rx_n == 0, "R7 held strobe", rx_n, 0);
      chk(c_r == 0, "R7 count", int'(c_r), 0);
   endtask

   task automatic t_single;
      int start;
      send_r(8'hA5, 2'b10, 0);
      start = rx_n;
      wait_cyc(15);
      chk(rx_n == start, "R2 long high", rx_n - start, 0);
      stb_r = 1'b0;
      wait_cyc(8);
      chk(rx_n == start, "R2 falling ignored", rx_n - start, 0);
   endtask

   task automatic t_delays;
      for (int d = 0; d < 8; d++) send_r(8'(8'h10 + d), 2'(d), d);
      stb_r = 1'b0;
      wait_cyc(12);
      dly_r = 3'd0;
   endtask

   task automatic t_idle;
      int start;
      start = rx_n;
      stb_r = 1'b0;
      wait_cyc(60);
      chk(rx_n == start, "R6 idle", rx_n - start, 0);
      send_r(8'h3C, 2'b01, 0);
      chk(rx_n == start + 1, "R6 resume", rx_n - start, 1);
      stb_r = 1'b0;
      wait_cyc(10);
   endtask

   task automatic t_stream;
      int start;
      int cstart;
      int bad;
      start  = rx_n;
      cstart = int'(c_r);
      for (int k = 0; k < 16; k++) begin
         stb_r    = 1'b0;
         ext_data = 8'(8'h40 + k * 3);
         ext_side = 2'(k);
         wait_cyc(2);
         stb_r = 1'b1;
         wait_cyc(2);
      end
      stb_r = 1'b0;
      wait_cyc(12);
      chk(rx_n == start + 16, "R9 word count", rx_n - start, 16);
      bad = 0;
      for (int k = 0; k < 16; k++)
         if (start + k < 64 && rx_data[start + k] != 8'(8'h40 + k * 3)) bad++;
      chk(bad == 0, "R9 word order", bad, 0);
      chk(int'(c_r) == cstart, "R8 wrap", int'(c_r), cstart);
   endtask

   task automatic t_fall;
      int start;
      start    = fx_n;
      ext_data = 8'hC3;
      ext_side = 2'b11;
      stb_f    = 1'b1;
      wait_cyc(10);
      chk(fx_n == start, "R3 rise ignored", fx_n - start, 0);
      stb_f = 1'b0;
      wait_cyc(2);
      chk(v_f == 1'b0, "R3 early", int'(v_f), 0);
      wait_cyc(1);
      chk(v_f == 1'b1 && d_f == 8'hC3 && s_f == 2'b11, "R3 capture",
          int'({v_f, s_f, d_f}), int'({1'b1, 2'b11, 8'hC3}));
      wait_cyc(1);
      chk(v_f == 1'b0 && fx_n == start + 1, "R3 one cycle", fx_n - start, 1);
   endtask

   initial begin
      t_reset;
      t_single;
      t_delays;
      t_idle;
      t_stream;
      t_fall;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule